// File: doc/BRIEF.md
# Queued SPI Master with Per-Frame Attributes

This block is an SPI master fed from a small transmit queue. Every queue entry holds one data word together with its own frame attributes: frame length, bit-rate select, chip-select pattern, clock polarity and an end-of-queue marker. The engine pulls entries one after another, so a run of frames can switch target device, bit rate or clock polarity from one frame to the next with no idle clock time and no software reconfiguration between them.

Received words go into a separate receive queue. Two request lines serve an external DMA engine or CPU. The transmit request means "room for another entry" and the receive request means "a received word is waiting". With the strobe option on, the top chip-select line acts as a strobe. It stays low for the first half bit-time of each frame while the other lines settle, so an external decoder sees no glitches on its select inputs.

The clock phase (CPHA) is a build parameter and defaults to 0: data is sampled on the leading clock edge. All eight lines of the chip-select pattern are active high and sit at zero while the block is idle.

Top module: `spi_cmd_master`

## Requirements
- R1: A transmit entry is 32 bits wide, laid out as follows:
  - data in [15:0]
  - frame length minus one in [19:16]
  - bit-rate select in [21:20]
  - chip-select pattern in [29:22]
  - clock polarity in [30]
  - end-of-queue flag in [31]

  The transmit queue holds TX_DEPTH (default 4) entries. `tx_req` is high while the queue has a free slot, and a push into a full queue is ignored.
- R2: A frame shifts size+1 bits out on `mosi`, most significant bit first. The word captured from `miso` is stored right-aligned and zero-extended, and received words leave the receive queue in frame order.
- R3: Each half bit-time lasts HALF_BASE<<select clock cycles. `sck` makes 2n-1 transitions inside an n-bit frame. Between frames `sck` rests at the polarity of the frame that just ended, and it changes only at the end of a half bit-time.
- R4: With CPHA=0, `mosi` is set up during the first half of each bit with `sck` at its idle level. `miso` is sampled on the edge that leaves the idle level.
- R5: `cs_o` carries the entry's pattern for the whole frame, stays unchanged inside a frame, and is zero when no frame is running.
- R6: With STROBE_EN=1, `cs_o[7]` is the strobe and pattern bit 7 enables it for that frame. When enabled, the strobe is low for the first half bit-time of the frame and high for the rest. When disabled, it stays low.
- R7: When a further entry is already queued, the next frame begins in the cycle right after the last half bit-time of the current one. Frame n then occupies exactly 2n half bit-times, with no gap between frames.
- R8: `rx_req` is high while the receive queue holds a word, `rx_data` shows the oldest word, and `rx_pop` removes it.
- R9: A frame that completes while the receive queue is full is discarded and sets `rx_ovf`, which stays set until reset.
- R10: `eoq_done` pulses for one cycle when a frame whose end-of-queue flag is set completes.
- R11: After reset the outputs take these values:

  | Output | Value |
  |---|---|
  | `sck` | 0 |
  | `mosi` | 0 |
  | `cs_o` | 0 |
  | `tx_req` | 1 |
  | `rx_req` | 0 |
  | `rx_ovf` | 0 |
  | `eoq_done` | 0 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Write `tx_entry` into the transmit queue |
| tx_entry | input | 32 | Queue entry: data plus frame attributes |
| tx_req | output | 1 | Transmit queue has a free slot |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_data | output | 16 | Oldest received word |
| rx_req | output | 1 | Receive queue is not empty |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 8 | Chip-select pattern, top line optionally a strobe |
| eoq_done | output | 1 | End-of-queue frame finished (one-cycle pulse) |
| rx_ovf | output | 1 | Sticky receive overflow |

## Verification
The assertions assume that `miso` changes only while `sck` is at its idle level within a bit. They also assume that entries are presented only through `tx_push` on clock edges, and that reset is applied at time zero.

The bench satisfies these assumptions with a loopback: `miso` follows `mosi`, optionally inverted by a control bit. That control bit changes only between batches, once every queued frame has drained. The bench drives all inputs on the falling clock edge.

// File: rtl/spi_q_pkg.sv
package spi_q_pkg;
  localparam int DATA_W = 16;
  localparam int CS_W   = 8;
  localparam int SIZE_W = 4;
  localparam int SEL_W  = 2;
  localparam int CNT_W  = 16;

  typedef struct packed {
    logic              eoq;
    logic              cpol;
    logic [CS_W-1:0]   cs;
    logic [SEL_W-1:0]  sel;
    logic [SIZE_W-1:0] size_m1;
    logic [DATA_W-1:0] data;
  } qent_t;

  localparam int ENT_W = $bits(qent_t);

  // cycles in one half bit-time
  function automatic logic [CNT_W-1:0] half_cycles(input logic [SEL_W-1:0] sel,
                                                   input int unsigned base);
    return CNT_W'(base << sel);
  endfunction

  // mask keeping the low size_m1+1 bits
  function automatic logic [DATA_W-1:0] len_mask(input logic [SIZE_W-1:0] size_m1);
    logic [31:0] m;
    m = (32'd1 << (32'(size_m1) + 32'd1)) - 32'd1;
    return m[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/spi_q_fifo.sv
module spi_q_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_q_engine.sv
module spi_q_engine
  import spi_q_pkg::*;
#(
  parameter int unsigned HALF_BASE = 1,
  parameter int          CPHA      = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ent_valid,
  input  qent_t             ent,
  output logic              take,
  output logic              busy,
  output logic              half_end,
  output logic              last_half,
  output logic              first_half,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_W-1:0]   cs_pat,
  output logic              frame_done,
  output logic              done_eoq,
  output logic [DATA_W-1:0] rx_word
);
  localparam logic PH = (CPHA != 0);
  localparam int   EW = SIZE_W + 1;

  qent_t             cur;
  logic [CNT_W-1:0]  hcnt;
  logic [EW-1:0]     edge_cnt;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic              sck_r;

  assign half_end   = busy && (hcnt == half_cycles(cur.sel, HALF_BASE) - CNT_W'(1));
  assign last_half  = half_end && (edge_cnt == {cur.size_m1, 1'b1});
  assign take       = ent_valid && (!busy || last_half);
  assign first_half = busy && (edge_cnt == '0);
  assign sck        = sck_r;
  assign mosi       = busy && tx_sh[cur.size_m1];
  assign cs_pat     = busy ? cur.cs : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cur        <= '0;
      hcnt       <= '0;
      edge_cnt   <= '0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      sck_r      <= 1'b0;
      frame_done <= 1'b0;
      done_eoq   <= 1'b0;
      rx_word    <= '0;
    end else begin
      frame_done <= 1'b0;
      if (last_half) begin
        frame_done <= 1'b1;
        done_eoq   <= cur.eoq;
        rx_word    <= rx_sh & len_mask(cur.size_m1);
      end
      if (take) begin
        busy     <= 1'b1;
        cur      <= ent;
        hcnt     <= '0;
        edge_cnt <= '0;
        tx_sh    <= ent.data;
        sck_r    <= ent.cpol ^ PH;
      end else if (last_half) begin
        busy  <= 1'b0;
        sck_r <= cur.cpol;
      end else if (half_end) begin
        hcnt     <= '0;
        edge_cnt <= edge_cnt + EW'(1);
        sck_r    <= ~sck_r;
        if (!edge_cnt[0]) rx_sh <= {rx_sh[DATA_W-2:0], miso};
        else              tx_sh <= tx_sh << 1;
      end else if (busy) begin
        hcnt <= hcnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_q_csdrv.sv
module spi_q_csdrv #(
  parameter int CSW       = 8,
  parameter int STROBE_EN = 1
) (
  input  logic           busy,
  input  logic           first_half,
  input  logic [CSW-1:0] pat,
  output logic [CSW-1:0] cs_o
);
  generate
    if (STROBE_EN != 0) begin : g_strobe
      assign cs_o[CSW-2:0] = pat[CSW-2:0];
      assign cs_o[CSW-1]   = busy && pat[CSW-1] && !first_half;
    end else begin : g_plain
      assign cs_o = pat;
    end
  endgenerate
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_q_pkg::*;
#(
  parameter int          TX_DEPTH  = 4,
  parameter int          RX_DEPTH  = 4,
  parameter int unsigned HALF_BASE = 1,
  parameter int          CPHA      = 0,
  parameter int          STROBE_EN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_push,
  input  logic [ENT_W-1:0]  tx_entry,
  output logic              tx_req,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_req,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_W-1:0]   cs_o,
  output logic              eoq_done,
  output logic              rx_ovf
);
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [ENT_W-1:0]  head;
  logic              eng_take, eng_busy, eng_half_end, eng_last, eng_first;
  logic              frame_done, done_eoq;
  logic [CS_W-1:0]   cs_pat;
  logic [DATA_W-1:0] rx_word;
  logic              ovf_r;

  spi_q_fifo #(.W(ENT_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_entry),
    .pop(eng_take), .dout(head), .full(tx_full), .empty(tx_empty));

  spi_q_engine #(.HALF_BASE(HALF_BASE), .CPHA(CPHA)) u_eng (
    .clk(clk), .rst_n(rst_n), .ent_valid(!tx_empty), .ent(qent_t'(head)),
    .take(eng_take), .busy(eng_busy), .half_end(eng_half_end),
    .last_half(eng_last), .first_half(eng_first), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_pat(cs_pat), .frame_done(frame_done),
    .done_eoq(done_eoq), .rx_word(rx_word));

  spi_q_csdrv #(.CSW(CS_W), .STROBE_EN(STROBE_EN)) u_cs (
    .busy(eng_busy), .first_half(eng_first), .pat(cs_pat), .cs_o(cs_o));

  spi_q_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(frame_done), .din(rx_word),
    .pop(rx_pop), .dout(rx_data), .full(rx_full), .empty(rx_empty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_r <= 1'b0;
    else if (frame_done && rx_full) ovf_r <= 1'b1;
  end

  assign tx_req   = !tx_full;
  assign rx_req   = !rx_empty;
  assign rx_ovf   = ovf_r;
  assign eoq_done = frame_done && done_eoq;
endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk #(
  parameter int CSW       = 8,
  parameter int STROBE_EN = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sck,
  input logic [CSW-1:0] cs_o,
  input logic           rx_req,
  input logic           rx_pop,
  input logic           rx_ovf,
  input logic           eoq_done,
  input logic           eng_busy,
  input logic           eng_take,
  input logic           eng_half_end,
  input logic           eng_last
);
  // R3: sck moves only at a half bit-time boundary or a frame start
  a_r3_sck_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_half_end && !eng_take) |=> $stable(sck));

  // R5: select lines hold still inside a frame
  a_r5_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !eng_take && !eng_last) |=> $stable(cs_o[CSW-2:0]));

  // R6: strobe is low in the first half bit-time of a frame
  a_r6_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((STROBE_EN != 0) && eng_take) |=> !cs_o[CSW-1]);

  // R8: a waiting word stays waiting until popped
  a_r8_rx_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && !rx_pop) |=> rx_req);

  // R9: overflow flag is sticky
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> rx_ovf);

  // R10: end-of-queue indication is a single-cycle pulse
  a_r10_eoq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eoq_done |=> !eoq_done);
endmodule

bind spi_cmd_master spi_cmd_master_chk #(.CSW(CS_W), .STROBE_EN(STROBE_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_o(cs_o), .rx_req(rx_req),
  .rx_pop(rx_pop), .rx_ovf(rx_ovf), .eoq_done(eoq_done),
  .eng_busy(eng_busy), .eng_take(eng_take), .eng_half_end(eng_half_end),
  .eng_last(eng_last));

// File: tb/spi_cmd_master_tb.sv
module spi_cmd_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BASE  = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_push = 1'b0;
  logic [31:0] tx_entry = '0;
  logic        tx_req, rx_req, sck, mosi, eoq_done, rx_ovf;
  logic        rx_pop = 1'b0;
  logic [15:0] rx_data;
  logic [7:0]  cs_o;
  logic        inv = 1'b0;
  logic        miso;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int eoq_cnt = 0;

  assign miso = mosi ^ inv;

  spi_cmd_master u_dut (
    .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_entry(tx_entry),
    .tx_req(tx_req), .rx_pop(rx_pop), .rx_data(rx_data), .rx_req(rx_req),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_o(cs_o),
    .eoq_done(eoq_done), .rx_ovf(rx_ovf));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (eoq_done) eoq_cnt++;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [15:0] d, input int sz, input int sel,
                                     input logic [7:0] cs, input bit cpol, input bit eoq);
    logic [31:0] e;
    e = {16'h0, d};
    e[19:16] = 4'(sz - 1);
    e[21:20] = 2'(sel);
    e[29:22] = cs;
    e[30]    = cpol;
    e[31]    = eoq;
    return e;
  endfunction

  function automatic logic [15:0] exp_rx(input logic [15:0] d, input int sz, input bit iv);
    logic [15:0] r = '0;
    for (int b = 0; b < sz; b++) r[b] = d[b] ^ iv;
    return r;
  endfunction

  function automatic int halfc(input int sel);
    int h = HALF_BASE;
    for (int k = 0; k < sel; k++) h = h * 2;
    return h;
  endfunction

  task automatic push_one(input logic [31:0] e);
    tx_entry = e;
    tx_push  = 1'b1;
    @(negedge clk);
    tx_push  = 1'b0;
  endtask

  task automatic pop_chk(input logic [15:0] exp, input string tag);
    chk(rx_req == 1'b1, {tag, " rx_req"}, 32'(rx_req), 32'd1);
    chk(rx_data == exp, tag, 32'(rx_data), 32'(exp));
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  logic [31:0] qe [4];
  logic [31:0] ov [6];

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    // R11: reset values
    chk(sck == 0 && mosi == 0, "R11 serial idle", {30'd0, sck, mosi}, 32'd0);
    chk(cs_o == 0, "R11 cs idle", 32'(cs_o), 32'd0);
    chk(tx_req && !rx_req && !rx_ovf && !eoq_done, "R11 flags",
        {28'd0, tx_req, rx_req, rx_ovf, eoq_done}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: two frames back to back, different rate, select and polarity
    begin
      logic [31:0] ea, eb;
      int fa, la, fb, lb, ta, tb2, sa, sb, w, pw, ps, e0;
      ea = mk(16'hA5C3, 8, 1, 8'h85, 1'b0, 1'b0);
      eb = mk(16'h0F09, 4, 0, 8'h8A, 1'b1, 1'b1);
      e0 = eoq_cnt;
      push_one(ea);
      push_one(eb);
      fa = -1; la = -1; fb = -1; lb = -1; ta = 0; tb2 = 0; sa = 0; sb = 0; pw = 0; ps = 0;
      for (int i = 0; i < 120; i++) begin
        w = (cs_o[6:0] == 7'h05) ? 1 : (cs_o[6:0] == 7'h0A) ? 2 : 0;
        if (w == 1) begin
          if (fa < 0) fa = i;
          la = i;
          if (pw == 1 && sck != ps) ta++;
          if (!cs_o[7]) sa++;
        end
        if (w == 2) begin
          if (fb < 0) fb = i;
          lb = i;
          if (pw == 2 && sck != ps) tb2++;
          if (!cs_o[7]) sb++;
        end
        pw = w; ps = sck;
        @(negedge clk);
      end
      chk(la - fa + 1 == 2*8*halfc(1), "R3 frame A length", 32'(la - fa + 1), 32'(2*8*halfc(1)));
      chk(lb - fb + 1 == 2*4*halfc(0), "R3 frame B length", 32'(lb - fb + 1), 32'(2*4*halfc(0)));
      chk(fb == la + 1, "R7 no gap between frames", 32'(fb), 32'(la + 1));
      chk(ta == 15, "R3 sck transitions A", 32'(ta), 32'd15);
      chk(tb2 == 7, "R3 sck transitions B", 32'(tb2), 32'd7);
      chk(sa == halfc(1), "R6 strobe low A", 32'(sa), 32'(halfc(1)));
      chk(sb == halfc(0), "R6 strobe low B", 32'(sb), 32'(halfc(0)));
      chk(sck == 1'b1, "R3 idle polarity after B", 32'(sck), 32'd1);
      chk(cs_o == 8'h00, "R5 cs released", 32'(cs_o), 32'd0);
      chk(eoq_cnt - e0 == 1, "R10 eoq count", 32'(eoq_cnt - e0), 32'd1);
      pop_chk(exp_rx(16'hA5C3, 8, 1'b0), "R2 R4 loopback A");
      pop_chk(exp_rx(16'h0F09, 4, 1'b0), "R2 R4 loopback B");
      chk(rx_req == 1'b0, "R8 rx drained", 32'(rx_req), 32'd0);
    end

    // Random batches
    for (int bt = 0; bt < 12; bt++) begin
      int k, ne, e0;
      bit lastp;
      k = 1 + int'($urandom % 4);
      inv = 1'($urandom % 2);
      ne = 0;
      e0 = eoq_cnt;
      lastp = 1'b0;
      for (int j = 0; j < k; j++) begin
        qe[j] = mk(16'($urandom), 4 + int'($urandom % 13), int'($urandom % 2),
                   8'($urandom), 1'($urandom % 2), 1'($urandom % 2));
        if (qe[j][31]) ne++;
        lastp = qe[j][30];
        push_one(qe[j]);
      end
      repeat (300) @(negedge clk);
      chk(sck == lastp, "R3 idle level follows last cpol", 32'(sck), 32'(lastp));
      chk(cs_o == 8'h00, "R5 idle cs", 32'(cs_o), 32'd0);
      chk(eoq_cnt - e0 == ne, "R10 eoq pulses", 32'(eoq_cnt - e0), 32'(ne));
      for (int j = 0; j < k; j++)
        pop_chk(exp_rx(qe[j][15:0], int'(qe[j][19:16]) + 1, inv), "R2 R1 random frame");
      chk(rx_req == 1'b0, "R8 empty after pops", 32'(rx_req), 32'd0);
    end
    chk(rx_ovf == 1'b0, "R9 no overflow yet", 32'(rx_ovf), 32'd0);
    inv = 1'b0;

    // Overflow and full transmit queue: six pushes in a row of slow frames
    for (int j = 0; j < 6; j++) begin
      ov[j] = mk(16'h1111 * 16'(j + 1), 16, 3, 8'h01, 1'b0, 1'b0);
      push_one(ov[j]);
    end
    chk(tx_req == 1'b0, "R1 tx_req low when full", 32'(tx_req), 32'd0);
    repeat (1400) @(negedge clk);
    chk(rx_ovf == 1'b1, "R9 overflow set", 32'(rx_ovf), 32'd1);
    chk(tx_req == 1'b1, "R1 tx_req back", 32'(tx_req), 32'd1);
    for (int j = 0; j < 4; j++) pop_chk(ov[j][15:0], "R9 kept words");
    chk(rx_req == 1'b0, "R1 R9 fifth dropped sixth ignored", 32'(rx_req), 32'd0);
    chk(rx_ovf == 1'b1, "R9 overflow sticky", 32'(rx_ovf), 32'd1);
    summary();
  end
endmodule